// File: doc/BRIEF.md
# Programmable chip-select strobe sequencer

This block produces the control strobes for one access to a simple asynchronous memory bank such as an SRAM, a ROM or a flash device. It drives an active-low chip-select, an active-low output-enable for reads and one active-low write-enable per byte lane for writes. A one-tick done pulse acknowledges the transfer. The block runs on a clock four times faster than the bus clock. Every strobe edge can therefore sit on a quarter-bus-clock boundary. All positions below are counted in these fast ticks: four ticks make one bus clock.

An access begins with a start pulse. The block then samples the direction, the byte-lane mask and the per-bank option fields, and holds them until the access ends. The option fields are:

- a 2-bit chip-select delay code;
- a wait-state count;
- a relaxed-timing bit;
- an early-negation bit for writes.

When the option inputs are marked not valid, the block uses built-in boot timing. A boot memory can then be read before software has programmed anything.

Top module: `cs_strobe_seq`

## Requirements
- R1: Out of reset and between accesses, cs_n, oe_n and every we_n bit are 1, and busy and done are 0. In the tick after the done pulse, all of them are back at these idle values.
- R2: A start pulse is accepted only while busy is 0. The fields are sampled at the edge that accepts it, and that tick is numbered tick 0. Busy is 1 from tick 0 through the done tick. A start pulse while busy is 1 is ignored, and so is any field change during the access.
- R3: An access lasts 4·C ticks, where C is its length in bus clocks. With relaxed timing off, C = 2 + W, where W (0 to 15) is the wait-state field. Done is 1 for exactly one tick, on tick 4·C − 1.
- R4: The chip-select delay code sets the tick on which cs_n falls: 00 gives tick 0, 10 gives tick 1 and 11 gives tick 2. The code 01 behaves as 00.
- R5: With relaxed timing on, C = 2 + 2·W when the delay code is 00 or 01, and C = 3 + 2·W when it is 10 or 11. This holds for reads, and for writes without early negation.
- R6: With relaxed timing on and a delay code of 10 or 11, cs_n falls four ticks later than R4 gives, on tick 5 or tick 6.
- R7: On a write with relaxed timing off and early negation set, the write-enables rise on tick 4·C − 1. Chip-select rises on that same tick only when the delay code is 10 or 11; otherwise it rises at the end of the access, at 4·C.
- R8: On a write with relaxed timing on and early negation set, C = 3 + 2·W for delay code 00/01 and C = 4 + 2·W for 10/11. The write-enables rise on tick 4·C − 5. Chip-select rises on that same tick only for delay code 10/11.
- R9: On a read, oe_n is low exactly while cs_n is low, and cs_n rises at 4·C. The early-negation bit has no effect on a read, and no we_n bit falls.
- R10: On a write, oe_n stays 1. The we_n bit of each lane whose mask bit is 1 falls on the same tick as cs_n. Lanes whose mask bit is 0 stay 1.
- R11: When opt_valid is 0 at the start pulse, the block ignores the option inputs and uses boot timing: delay code 11, W = 15, relaxed on and early negation off. A boot read therefore lasts 33 bus clocks, and cs_n falls on tick 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four ticks per bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-tick request to begin an access |
| wr | input | 1 | 1 for a write, 0 for a read |
| lanes | input | 4 | Byte lanes to write, bit i for lane i |
| opt_valid | input | 1 | 1 if the option fields are programmed, 0 to use boot timing |
| opt_acs | input | 2 | Chip-select delay code |
| opt_wait | input | 4 | Wait-state count |
| opt_relax | input | 1 | Relaxed-timing enable |
| opt_early | input | 1 | Early strobe negation on writes |
| cs_n | output | 1 | Chip-select, active low |
| oe_n | output | 1 | Output-enable, active low |
| we_n | output | 4 | Per-lane write-enables, active low |
| done | output | 1 | One-tick end-of-access pulse |
| busy | output | 1 | Access in progress |

## Verification
A start pulse driven before a rising edge is accepted at that edge. The first falling edge after it shows tick 0. Every strobe then follows combinationally from the tick counter, so the value seen at the k-th falling edge after acceptance is the value for tick k. The bench walks each access one falling edge at a time, from tick 0 to two ticks past the expected end. At each tick it records where each strobe first goes low and for how many ticks it stays low, and compares these with positions worked out from the requirement formulas. The done tick, the busy length and the return to idle are compared the same way, using tick 4·C − 1 and the ticks after it.

// File: rtl/cs_seq_pkg.sv
`timescale 1ns/1ps
package cs_seq_pkg;

    localparam int WAIT_W    = 4;
    localparam int LANES     = 4;
    localparam int TPC       = 4;
    localparam int MAX_WAIT  = (1 << WAIT_W) - 1;
    localparam int MAX_CLK   = 4 + 2 * MAX_WAIT;
    localparam int MAX_TICKS = TPC * MAX_CLK;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    localparam logic [1:0]        BOOT_ACS   = 2'b11;
    localparam logic [WAIT_W-1:0] BOOT_WAIT  = WAIT_W'(MAX_WAIT);
    localparam logic              BOOT_RELAX = 1'b1;
    localparam logic              BOOT_EARLY = 1'b0;

    typedef logic [CNT_W-1:0] tick_t;

    typedef struct packed {
        logic [1:0]        acs;
        logic [WAIT_W-1:0] waits;
        logic              relax;
        logic              early;
    } opt_t;

    typedef struct packed {
        tick_t             cs_on;
        tick_t             cs_off;
        tick_t             we_off;
        tick_t             last;
        logic              wr;
        logic [LANES-1:0]  lanes;
    } plan_t;

    function automatic int acs_ticks(input logic [1:0] acs);
        case (acs)
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 0;
        endcase
    endfunction

    function automatic plan_t build_plan(input opt_t o, input logic wr,
                                         input logic [LANES-1:0] lanes);
        plan_t p;
        int    clocks;
        int    total;
        int    lag;
        int    on;
        logic  delayed;
        logic  early_w;
        delayed = (o.acs == 2'b10) || (o.acs == 2'b11);
        early_w = wr & o.early;
        if (o.relax)
            clocks = 2 + 2 * int'(o.waits) + (delayed ? 1 : 0) + (early_w ? 1 : 0);
        else
            clocks = 2 + int'(o.waits);
        total = clocks * TPC;
        on    = acs_ticks(o.acs) + ((o.relax && delayed) ? TPC : 0);
        lag   = !early_w ? 0 : (o.relax ? TPC + 1 : 1);
        p.cs_on  = tick_t'(on);
        p.we_off = tick_t'(total - lag);
        p.cs_off = delayed ? tick_t'(total - lag) : tick_t'(total);
        p.last   = tick_t'(total - 1);
        p.wr     = wr;
        p.lanes  = lanes;
        return p;
    endfunction

endpackage

// File: rtl/cs_seq_opt_sel.sv
`timescale 1ns/1ps
module cs_seq_opt_sel
    import cs_seq_pkg::*;
(
    input  logic              opt_valid,
    input  logic [1:0]        opt_acs,
    input  logic [WAIT_W-1:0] opt_wait,
    input  logic              opt_relax,
    input  logic              opt_early,
    input  logic              wr,
    input  logic [LANES-1:0]  lanes,
    output plan_t             plan
);
    opt_t sel;

    always_comb begin
        if (opt_valid) begin
            sel.acs   = opt_acs;
            sel.waits = opt_wait;
            sel.relax = opt_relax;
            sel.early = opt_early;
        end else begin
            sel.acs   = BOOT_ACS;
            sel.waits = BOOT_WAIT;
            sel.relax = BOOT_RELAX;
            sel.early = BOOT_EARLY;
        end
        plan = build_plan(sel, wr, lanes);
    end
endmodule

// File: rtl/cs_seq_timer.sv
`timescale 1ns/1ps
module cs_seq_timer
    import cs_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  plan_t plan_in,
    output plan_t plan_q,
    output tick_t tick,
    output logic  busy,
    output logic  done
);
    logic  active;
    logic  at_last;

    assign at_last = (tick == plan_q.last);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            tick   <= '0;
            plan_q <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                tick   <= '0;
                plan_q <= plan_in;
            end
        end else if (at_last) begin
            active <= 1'b0;
        end else begin
            tick <= tick + 1'b1;
        end
    end

    assign busy = active;
    assign done = active && at_last;
endmodule

// File: rtl/cs_seq_strobes.sv
`timescale 1ns/1ps
module cs_seq_strobes
    import cs_seq_pkg::*;
(
    input  logic             busy,
    input  tick_t            tick,
    input  tick_t            cs_on,
    input  tick_t            cs_off,
    input  tick_t            we_off,
    input  logic             wr,
    input  logic [LANES-1:0] lanes,
    output logic             cs_n,
    output logic             oe_n,
    output logic [LANES-1:0] we_n
);
    logic past_on;
    logic cs_win;
    logic we_win;

    assign past_on = busy && (tick >= cs_on);
    assign cs_win  = past_on && (tick < cs_off);
    assign we_win  = past_on && wr && (tick < we_off);

    assign cs_n = !cs_win;
    assign oe_n = !(cs_win && !wr);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign we_n[i] = !(we_win && lanes[i]);
    end
endmodule

// File: rtl/cs_strobe_seq.sv
`timescale 1ns/1ps
module cs_strobe_seq
    import cs_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic [LANES-1:0]  lanes,
    input  logic              opt_valid,
    input  logic [1:0]        opt_acs,
    input  logic [WAIT_W-1:0] opt_wait,
    input  logic              opt_relax,
    input  logic              opt_early,
    output logic              cs_n,
    output logic              oe_n,
    output logic [LANES-1:0]  we_n,
    output logic              done,
    output logic              busy
);
    plan_t plan_new;
    plan_t plan_q;
    tick_t tick;

    cs_seq_opt_sel u_sel (
        .opt_valid (opt_valid),
        .opt_acs   (opt_acs),
        .opt_wait  (opt_wait),
        .opt_relax (opt_relax),
        .opt_early (opt_early),
        .wr        (wr),
        .lanes     (lanes),
        .plan      (plan_new)
    );

    cs_seq_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .plan_in (plan_new),
        .plan_q  (plan_q),
        .tick    (tick),
        .busy    (busy),
        .done    (done)
    );

    cs_seq_strobes u_strobes (
        .busy   (busy),
        .tick   (tick),
        .cs_on  (plan_q.cs_on),
        .cs_off (plan_q.cs_off),
        .we_off (plan_q.we_off),
        .wr     (plan_q.wr),
        .lanes  (plan_q.lanes),
        .cs_n   (cs_n),
        .oe_n   (oe_n),
        .we_n   (we_n)
    );
endmodule

// File: rtl/cs_strobe_seq_chk.sv
`timescale 1ns/1ps
module cs_strobe_seq_chk
    import cs_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             cs_n,
    input logic             oe_n,
    input logic [LANES-1:0] we_n
);
    assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_ends_on_done_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    assert_idle_after_done_R1: assert property (@(posedge clk) disable iff (rst)
        done |=> (cs_n && oe_n && (&we_n) && !busy));

    assert_oe_inside_cs_R9: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !cs_n);

    assert_oe_we_apart_R9: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (&we_n));

    assert_we_inside_cs_R10: assert property (@(posedge clk) disable iff (rst)
        !(&we_n) |-> !cs_n);
endmodule

bind cs_strobe_seq cs_strobe_seq_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .busy (busy),
    .done (done),
    .cs_n (cs_n),
    .oe_n (oe_n),
    .we_n (we_n)
);

// File: tb/cs_strobe_seq_bench.sv
`timescale 1ns/1ps
module cs_strobe_seq_bench;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          wr = 1'b0;
    logic [NL-1:0] lanes = '0;
    logic          opt_valid = 1'b1;
    logic [1:0]    opt_acs = 2'b00;
    logic [3:0]    opt_wait = 4'd0;
    logic          opt_relax = 1'b0;
    logic          opt_early = 1'b0;
    logic          cs_n;
    logic          oe_n;
    logic [NL-1:0] we_n;
    logic          done;
    logic          busy;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cs_strobe_seq u_cs_strobe_seq (
        .clk(clk), .rst(rst), .start(start), .wr(wr), .lanes(lanes),
        .opt_valid(opt_valid), .opt_acs(opt_acs), .opt_wait(opt_wait),
        .opt_relax(opt_relax), .opt_early(opt_early),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_clocks(input bit w_, input bit [1:0] acs,
                                      input int ws, input bit rx, input bit er);
        bit d = (acs == 2'b10) || (acs == 2'b11);
        bit e = w_ && er;
        if (!rx) return 2 + ws;
        if (!e) return d ? 3 + 2 * ws : 2 + 2 * ws;
        return d ? 4 + 2 * ws : 3 + 2 * ws;
    endfunction

    // One access; inj >= 0 pulses a second start (with other fields) on that tick
    task automatic run_access(input string req, input bit w_, input bit [NL-1:0] ln,
                              input bit valid, input bit [1:0] acs, input int ws,
                              input bit rx, input bit er, input int inj);
        bit [1:0] e_acs = valid ? acs : 2'b11;
        int       e_ws  = valid ? ws : 15;
        bit       e_rx  = valid ? rx : 1'b1;
        bit       e_er  = valid ? er : 1'b0;
        bit       d     = (e_acs == 2'b10) || (e_acs == 2'b11);
        bit       e     = w_ && e_er;
        int       n     = 4 * exp_clocks(w_, e_acs, e_ws, e_rx, e_er);
        int       on    = (e_acs == 2'b10) ? 1 : (e_acs == 2'b11) ? 2 : 0;
        int       lag   = !e ? 0 : (e_rx ? 5 : 1);
        int       csoff, weoff;
        int       busy_cnt = 0, done_cnt = 0, done_at = -1;
        int       cs_first = -1, cs_cnt = 0, oe_first = -1, oe_cnt = 0;
        int       we_first[NL], we_cnt[NL];
        int       idle_bad = 0;
        if (e_rx && d) on += 4;
        csoff = d ? n - lag : n;
        weoff = n - lag;
        for (int i = 0; i < NL; i++) begin we_first[i] = -1; we_cnt[i] = 0; end

        @(negedge clk);
        wr = w_; lanes = ln; opt_valid = valid; opt_acs = acs;
        opt_wait = 4'(ws); opt_relax = rx; opt_early = er; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n + 2; k++) begin
            if (busy) busy_cnt++;
            if (done) begin done_cnt++; done_at = k; end
            if (!cs_n) begin if (cs_first < 0) cs_first = k; cs_cnt++; end
            if (!oe_n) begin if (oe_first < 0) oe_first = k; oe_cnt++; end
            for (int i = 0; i < NL; i++)
                if (!we_n[i]) begin if (we_first[i] < 0) we_first[i] = k; we_cnt[i]++; end
            if (k >= n && !(cs_n && oe_n && (&we_n) && !busy && !done)) idle_bad++;
            if (k == inj) begin
                start = 1'b1; opt_wait = 4'd0; opt_relax = 1'b0; wr = ~w_;
                opt_acs = 2'b00; lanes = ~ln;
            end
            if (k == inj + 1) begin
                start = 1'b0; opt_wait = 4'(ws); opt_relax = rx; wr = w_;
                opt_acs = acs; lanes = ln;
            end
            @(negedge clk);
        end

        check(busy_cnt == n, {req, " R2"}, "busy length", busy_cnt, n);
        check(done_at == n - 1 && done_cnt == 1, {req, " R3"}, "done tick",
              done_at * 100 + done_cnt, (n - 1) * 100 + 1);
        check(idle_bad == 0, {req, " R1"}, "idle after done", idle_bad, 0);
        check(cs_first == on, {req, " R4"}, "cs fall tick", cs_first, on);
        check(cs_cnt == csoff - on, req, "cs low ticks", cs_cnt, csoff - on);
        if (w_) begin
            check(oe_cnt == 0, {req, " R10"}, "oe low ticks on write", oe_cnt, 0);
            for (int i = 0; i < NL; i++) begin
                check(we_first[i] == (ln[i] ? on : -1), {req, " R10"}, "we fall tick",
                      we_first[i], ln[i] ? on : -1);
                check(we_cnt[i] == (ln[i] ? weoff - on : 0), req, "we low ticks",
                      we_cnt[i], ln[i] ? weoff - on : 0);
            end
        end else begin
            check(oe_first == on && oe_cnt == csoff - on, {req, " R9"}, "oe window",
                  oe_first * 1000 + oe_cnt, on * 1000 + csoff - on);
            check(we_cnt[0] + we_cnt[1] + we_cnt[2] + we_cnt[3] == 0, {req, " R9"},
                  "we on read", we_cnt[0] + we_cnt[1] + we_cnt[2] + we_cnt[3], 0);
        end
    endtask

    task automatic test_reset;
        @(negedge clk);
        check(cs_n && oe_n && (&we_n) && !busy && !done, "R1", "reset idle",
              {27'd0, cs_n, oe_n, busy, done, &we_n}, 5'b11001);
    endtask

    task automatic test_plain;
        run_access("R3", 1'b0, 4'h0, 1'b1, 2'b00, 0, 1'b0, 1'b0, -1);
        run_access("R4", 1'b0, 4'h0, 1'b1, 2'b10, 3, 1'b0, 1'b0, -1);
        run_access("R9", 1'b0, 4'h0, 1'b1, 2'b11, 1, 1'b0, 1'b1, -1);
        run_access("R4", 1'b0, 4'h0, 1'b1, 2'b01, 2, 1'b0, 1'b0, -1);
        run_access("R10", 1'b1, 4'b0101, 1'b1, 2'b00, 2, 1'b0, 1'b0, -1);
    endtask

    task automatic test_early;
        run_access("R7", 1'b1, 4'b1111, 1'b1, 2'b10, 1, 1'b0, 1'b1, -1);
        run_access("R7", 1'b1, 4'b0011, 1'b1, 2'b00, 0, 1'b0, 1'b1, -1);
    endtask

    task automatic test_relaxed;
        run_access("R5", 1'b0, 4'h0, 1'b1, 2'b00, 2, 1'b1, 1'b0, -1);
        run_access("R6", 1'b0, 4'h0, 1'b1, 2'b11, 1, 1'b1, 1'b0, -1);
        run_access("R8", 1'b1, 4'b1111, 1'b1, 2'b10, 2, 1'b1, 1'b1, -1);
        run_access("R8", 1'b1, 4'b1000, 1'b1, 2'b00, 0, 1'b1, 1'b1, -1);
        run_access("R8", 1'b1, 4'b1110, 1'b1, 2'b11, 15, 1'b1, 1'b1, -1);
    endtask

    task automatic test_boot;
        run_access("R11", 1'b0, 4'h0, 1'b0, 2'b00, 0, 1'b0, 1'b1, -1);
    endtask

    task automatic test_ignore_start;
        run_access("R2", 1'b1, 4'b0110, 1'b1, 2'b10, 15, 1'b0, 1'b0, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_plain();
        test_early();
        test_relaxed();
        test_boot();
        test_ignore_start();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule